// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of a mobile DDR SDRAM. It takes the device into one of two low-power modes and brings it back out. It owns the clock-enable pin and the four command strobes for as long as a low-power episode lasts. Ordinary power-down keeps the array contents. It becomes active power-down when any row is open at the moment the clock enable drops, and precharge power-down when no row is open. Deep power-down switches the array off and is entered with its own command. After a deep power-down the memory holds no valid data and must be fully initialized again.

The main controller raises one-cycle requests to enter power-down, to enter deep power-down or to leave. It also supplies three status flags: a bank is open, a column access is in progress, and the row-precharge time has elapsed. A request is held pending until its entry conditions are met. The sequencer applies the minimum clock-enable level time, the exit-to-command delay and a ceiling on power-down residency. It reports its mode as a 3-bit code and keeps a reinitialization flag raised after every deep power-down exit until the controller acknowledges it.

Top module: `lpm_sequencer`

## Requirements
- R1: Deep power-down is entered only when `bank_open` is 0, `access_busy` is 0 and `trp_met` is 1 at the deciding clock edge. A deep power-down request that arrives while these conditions fail is held, and the block enters once they hold.
- R2: Deep power-down entry drives `cke` low in the same cycle as the command `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=0, and `mode` becomes 3.
- R3: While `mode` is 3, `cke` stays 0 and the bus shows deselect (`cs_n`=1). The residency ceiling of R10 does not end deep power-down.
- R4: Power-down is entered only when `access_busy` is 0. A power-down request made while an access is running is held and taken on the first edge at which `access_busy` is 0.
- R5: Power-down entry drops `cke` with a NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1). `mode` becomes 2 (active) if `bank_open` was 1 at entry and 1 (precharge) otherwise. From the next cycle the bus shows deselect.
- R6: A pending exit request in any low-power mode raises `cke` together with a NOP and sets `mode` to 4.
- R7: `init_required` is set by an exit from deep power-down and stays set until `init_ack`. An exit from power-down does not set it.
- R8: Every `cke` level is held for at least `TCKE` cycles before it changes.
- R9: `mode` returns from 4 to 0 exactly `TXP` cycles after `cke` rises.
- R10: If no exit is requested, power-down ends by itself after `max(TPD_MAX, TCKE)` cycles with `cke` low.
- R11: Entry requests made when `mode` is not 0 are discarded. Exit requests made while `mode` is 0 or 4 are discarded.
- R12: After reset, `cke` is 1, the bus carries a NOP, `mode` is 0 and `init_required` is 0.
- R13: While a deep power-down request is pending, a power-down request does not cause entry. Entering deep power-down also clears any pending power-down request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pd | input | 1 | One-cycle request to enter power-down |
| req_dpd | input | 1 | One-cycle request to enter deep power-down |
| req_exit | input | 1 | One-cycle request to leave the low-power mode |
| bank_open | input | 1 | At least one row is open |
| access_busy | input | 1 | A read or write burst is in progress |
| trp_met | input | 1 | Row-precharge time satisfied |
| init_ack | input | 1 | Controller has taken note of the reinitialization need |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mode | output | 3 | 0 idle, 1 precharge power-down, 2 active power-down, 3 deep power-down, 4 exiting |
| init_required | output | 1 | Full initialization needed before normal use |

## Verification
The bench builds the block with `TCKE`=3, `TXP`=2 and `TPD_MAX`=20. These values are small enough that a request arriving just after entry still hits the minimum-level wait, and the exiting state can be observed for two separate cycles. They also let the bench wait out the automatic power-down exit and then stay in deep power-down beyond that same ceiling, all in a few dozen cycles. With a 3-cycle level minimum, the first edge that may move `cke` can be told apart from the edges just before and after it.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power sequencer: mode codes and the command strobe bundle.
package lpm_pkg;

    typedef enum logic [2:0] {
        LPM_IDLE   = 3'd0,
        LPM_PD_PRE = 3'd1,
        LPM_PD_ACT = 3'd2,
        LPM_DPD    = 3'd3,
        LPM_EXIT   = 3'd4
    } lpm_mode_e;

    // Strobes ordered cs_n, ras_n, cas_n, we_n (most significant first).
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } lpm_cmd_t;

    localparam lpm_cmd_t CMD_NOP   = 4'b0111;
    localparam lpm_cmd_t CMD_DESEL = 4'b1111;
    localparam lpm_cmd_t CMD_DPD   = 4'b0110;

endpackage

// File: rtl/lpm_countdown.sv
// Loadable down-counter. done is high whenever the count is zero.
// Assumes: load has priority; the count stops at zero; reset leaves it at zero (done).
module lpm_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count toward zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpm_pending.sv
// Bank of request-holding flags, one per request kind.
// Assumes: clear wins over set in the same cycle.
module lpm_pending #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one request until it is consumed.
        always_ff @(posedge clk) begin
            if (!rst_n)      pend[g] <= 1'b0;
            else if (clr[g]) pend[g] <= 1'b0;
            else if (set[g]) pend[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/lpm_fsm.sv
// Mode state machine. It decides entry and exit from pending requests, status flags and
// timer states, and registers CKE, the command strobes and the reinit flag.
// Assumes: the timers are loaded through the ld_* pulses in the cycle a transition is taken.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_pend,
    input  logic      dpd_pend,
    input  logic      exit_pend,
    input  logic      bank_open,
    input  logic      access_busy,
    input  logic      trp_met,
    input  logic      init_ack,
    input  logic      cke_done,
    input  logic      xp_done,
    input  logic      res_done,
    output lpm_mode_e state,
    output logic      cke,
    output lpm_cmd_t  cmd,
    output logic      init_required,
    output logic      clr_pd,
    output logic      clr_dpd,
    output logic      clr_exit,
    output logic      ld_cke,
    output logic      ld_xp,
    output logic      ld_res
);
    logic in_pd;
    logic go_dpd;
    logic go_pd;
    logic go_exit;

    // Transition decisions for this cycle.
    always_comb begin
        in_pd   = (state == LPM_PD_PRE) || (state == LPM_PD_ACT);
        go_dpd  = (state == LPM_IDLE) && dpd_pend && !bank_open && !access_busy
                  && trp_met && cke_done;
        go_pd   = (state == LPM_IDLE) && !dpd_pend && pd_pend && !access_busy && cke_done;
        go_exit = cke_done && ((in_pd && (exit_pend || res_done))
                  || ((state == LPM_DPD) && exit_pend));
    end

    assign clr_dpd  = go_dpd;
    assign clr_pd   = go_pd || go_dpd;
    assign clr_exit = go_exit;
    assign ld_cke   = go_dpd || go_pd || go_exit;
    assign ld_xp    = go_exit;
    assign ld_res   = go_pd;

    // Mode register together with the registered pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LPM_IDLE;
            cke   <= 1'b1;
            cmd   <= CMD_NOP;
        end else if (go_dpd) begin
            state <= LPM_DPD;
            cke   <= 1'b0;
            cmd   <= CMD_DPD;
        end else if (go_pd) begin
            state <= bank_open ? LPM_PD_ACT : LPM_PD_PRE;
            cke   <= 1'b0;
            cmd   <= CMD_NOP;
        end else if (go_exit) begin
            state <= LPM_EXIT;
            cke   <= 1'b1;
            cmd   <= CMD_NOP;
        end else if ((state == LPM_EXIT) && xp_done) begin
            state <= LPM_IDLE;
            cmd   <= CMD_NOP;
        end else if (in_pd || (state == LPM_DPD)) begin
            cmd   <= CMD_DESEL;
        end
    end

    // Reinit flag: set on leaving deep power-down, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                            init_required <= 1'b0;
        else if (go_exit && state == LPM_DPD)  init_required <= 1'b1;
        else if (init_ack)                     init_required <= 1'b0;
    end
endmodule

// File: rtl/lpm_sequencer.sv
// Top of the low-power sequencer: request capture, three timers (CKE level minimum,
// exit-to-command delay, power-down residency) and the mode state machine.
// Assumes: requests are single-cycle pulses; status flags are synchronous to clk.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int TCKE    = 3,
    parameter int TXP     = 2,
    parameter int TPD_MAX = 7800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_pd,
    input  logic       req_dpd,
    input  logic       req_exit,
    input  logic       bank_open,
    input  logic       access_busy,
    input  logic       trp_met,
    input  logic       init_ack,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic [2:0] mode,
    output logic       init_required
);
    localparam int CKE_W = $clog2(TCKE + 1);
    localparam int XP_W  = $clog2(TXP + 1);
    localparam int RES_W = $clog2(TPD_MAX + 1);
    localparam logic [CKE_W-1:0] CKE_LD = CKE_W'(TCKE - 1);
    localparam logic [XP_W-1:0]  XP_LD  = XP_W'(TXP - 1);
    localparam logic [RES_W-1:0] RES_LD = RES_W'(TPD_MAX - 1);

    lpm_mode_e  st;
    lpm_cmd_t   cmd;
    logic [2:0] set_v, clr_v, pend_v;
    logic       ld_cke, ld_xp, ld_res;
    logic       cke_done, xp_done, res_done;
    logic       is_idle, is_lp;

    // Request acceptance windows per mode.
    always_comb begin
        is_idle  = (st == LPM_IDLE);
        is_lp    = (st == LPM_PD_PRE) || (st == LPM_PD_ACT) || (st == LPM_DPD);
        set_v[0] = req_pd  && is_idle;
        set_v[1] = req_dpd && is_idle;
        set_v[2] = req_exit && is_lp;
    end

    lpm_pending #(.N(3)) pend_i (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend_v)
    );

    lpm_countdown #(.W(CKE_W)) cke_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ld_cke), .load_val(CKE_LD), .done(cke_done)
    );

    lpm_countdown #(.W(XP_W)) xp_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ld_xp), .load_val(XP_LD), .done(xp_done)
    );

    lpm_countdown #(.W(RES_W)) res_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(ld_res), .load_val(RES_LD), .done(res_done)
    );

    lpm_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .pd_pend(pend_v[0]), .dpd_pend(pend_v[1]), .exit_pend(pend_v[2]),
        .bank_open(bank_open), .access_busy(access_busy), .trp_met(trp_met),
        .init_ack(init_ack),
        .cke_done(cke_done), .xp_done(xp_done), .res_done(res_done),
        .state(st), .cke(cke), .cmd(cmd), .init_required(init_required),
        .clr_pd(clr_v[0]), .clr_dpd(clr_v[1]), .clr_exit(clr_v[2]),
        .ld_cke(ld_cke), .ld_xp(ld_xp), .ld_res(ld_res)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign mode  = st;
endmodule

// File: rtl/lpm_sequencer_chk.sv
// Property checker for the low-power sequencer, attached by bind. It keeps its own
// age counter for the current CKE level so that window checks need no deep $past.
module lpm_sequencer_chk #(
    parameter int TCKE    = 3,
    parameter int TXP     = 2,
    parameter int TPD_MAX = 7800
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bank_open,
    input logic       access_busy,
    input logic       trp_met,
    input logic       init_ack,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [2:0] mode,
    input logic       init_required
);
    localparam int M1  = (TCKE > TXP) ? TCKE : TXP;
    localparam int LIM = (TPD_MAX > TCKE) ? TPD_MAX : TCKE;
    localparam int CAP = ((M1 > TPD_MAX) ? M1 : TPD_MAX) + 1;
    localparam int AW  = $clog2(CAP + 1);

    logic [AW-1:0] age;
    logic          prv_cke;
    logic          is_nop, is_dpd_cmd;

    assign is_nop     = !cs_n && ras_n && cas_n && we_n;
    assign is_dpd_cmd = !cs_n && ras_n && cas_n && !we_n;

    // Track how long the current CKE level has been held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_cke <= 1'b1;
            age     <= AW'(CAP);
        end else begin
            prv_cke <= cke;
            if (cke != prv_cke)     age <= AW'(1);
            else if (age < AW'(CAP)) age <= age + 1'b1;
        end
    end

    AST_DPD_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
        is_dpd_cmd |-> $past(!bank_open && !access_busy && trp_met)); // R1
    AST_DPD_CMD_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        is_dpd_cmd |-> (!cke && $past(cke) && mode == 3'd3)); // R2
    AST_DPD_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> !cke); // R3
    AST_PD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && mode != 3'd3) |-> $past(!access_busy)); // R4
    AST_PD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && mode != 3'd3) |-> (is_nop && mode == ($past(bank_open) ? 3'd2 : 3'd1))); // R5
    AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (is_nop && mode == 3'd4)); // R6
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (init_required && !init_ack) |=> init_required); // R7
    AST_CKE_MIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != prv_cke) |-> (age >= AW'(TCKE))); // R8
    AST_XP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd4 && mode == 3'd0) |-> (cke && age >= AW'(TXP))); // R9
    AST_PD_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !prv_cke && ($past(mode) == 3'd1 || $past(mode) == 3'd2)) |-> (age <= AW'(LIM))); // R10
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.TCKE(TCKE), .TXP(TXP), .TPD_MAX(TPD_MAX)) chk_i (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .access_busy(access_busy),
    .trp_met(trp_met), .init_ack(init_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .mode(mode), .init_required(init_required)
);

// File: tb/lpm_sequencer_tb.sv
// Directed bench for the low-power sequencer: one task per scenario.
module lpm_sequencer_tb_top;
    localparam int CLK_P   = 10;
    localparam int TCKE    = 3;
    localparam int TXP     = 2;
    localparam int TPD_MAX = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_pd = 1'b0, req_dpd = 1'b0, req_exit = 1'b0;
    logic       bank_open = 1'b0, access_busy = 1'b0, trp_met = 1'b1, init_ack = 1'b0;
    logic       cke, cs_n, ras_n, cas_n, we_n, init_required;
    logic [2:0] mode;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P / 2) clk = ~clk;

    lpm_sequencer #(.TCKE(TCKE), .TXP(TXP), .TPD_MAX(TPD_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_pd(req_pd), .req_dpd(req_dpd), .req_exit(req_exit),
        .bank_open(bank_open), .access_busy(access_busy), .trp_met(trp_met),
        .init_ack(init_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .mode(mode), .init_required(init_required)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int bus();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic pulse_pd();   req_pd = 1'b1;   tick(1); req_pd = 1'b0;   endtask
    task automatic pulse_dpd();  req_dpd = 1'b1;  tick(1); req_dpd = 1'b0;  endtask
    task automatic pulse_exit(); req_exit = 1'b1; tick(1); req_exit = 1'b0; endtask

    task automatic t_reset();
        check("R12 cke after reset", cke, 1);
        check("R12 bus NOP after reset", bus(), 4'b0111);
        check("R12 mode after reset", mode, 0);
        check("R12 init_required after reset", init_required, 0);
    endtask

    task automatic t_pd_precharge();
        bank_open = 1'b0;
        pulse_pd();
        check("R5 cke before entry edge", cke, 1);
        tick(1);
        check("R5 cke low at entry", cke, 0);
        check("R5 precharge mode", mode, 1);
        check("R5 entry bus NOP", bus(), 4'b0111);
        pulse_exit();
        check("R5 deselect during power-down", bus(), 4'b1111);
        tick(1);
        check("R8 cke still low before tCKE", cke, 0);
        tick(1);
        check("R6 cke high on exit", cke, 1);
        check("R6 exit mode", mode, 4);
        check("R6 exit bus NOP", bus(), 4'b0111);
        tick(1);
        check("R9 still exiting", mode, 4);
        tick(1);
        check("R9 idle after tXP", mode, 0);
        check("R7 no reinit after power-down", init_required, 0);
        tick(4);
    endtask

    task automatic t_pd_active_limit();
        bank_open = 1'b1;
        pulse_pd();
        tick(1);
        check("R5 active mode", mode, 2);
        bank_open = 1'b0;
        tick(TPD_MAX - 1);
        check("R10 still low before limit", cke, 0);
        tick(1);
        check("R10 forced exit cke", cke, 1);
        check("R10 forced exit mode", mode, 4);
        tick(TXP + 4);
        check("R10 back to idle", mode, 0);
    endtask

    task automatic t_pd_busy_hold();
        access_busy = 1'b1;
        pulse_pd();
        tick(3);
        check("R4 no entry while busy", cke, 1);
        check("R4 mode idle while busy", mode, 0);
        access_busy = 1'b0;
        tick(1);
        check("R4 entry once access ends", cke, 0);
        check("R4 mode after held entry", mode, 1);
        pulse_exit();
        tick(TCKE + TXP + 4);
        check("R4 idle after exit", mode, 0);
    endtask

    task automatic t_dpd_cycle();
        bank_open = 1'b1;
        trp_met = 1'b1;
        pulse_dpd();
        tick(3);
        check("R1 no deep entry with open bank", cke, 1);
        pulse_pd();
        tick(2);
        check("R13 power-down blocked by pending deep request", cke, 1);
        bank_open = 1'b0;
        trp_met = 1'b0;
        tick(2);
        check("R1 no deep entry before precharge time", cke, 1);
        access_busy = 1'b1;
        trp_met = 1'b1;
        tick(2);
        check("R1 no deep entry during access", cke, 1);
        access_busy = 1'b0;
        tick(1);
        check("R2 cke low at deep entry", cke, 0);
        check("R2 deep command", bus(), 4'b0110);
        check("R2 deep mode", mode, 3);
        tick(1);
        check("R3 deselect in deep mode", bus(), 4'b1111);
        tick(TPD_MAX + 5);
        check("R3 cke stays low past ceiling", cke, 0);
        check("R3 mode stays deep", mode, 3);
        pulse_exit();
        tick(1);
        check("R6 cke high on deep exit", cke, 1);
        check("R6 deep exit mode", mode, 4);
        check("R7 reinit set on deep exit", init_required, 1);
        tick(TXP + 6);
        check("R13 pending power-down dropped by deep entry", mode, 0);
        check("R7 reinit still set", init_required, 1);
        init_ack = 1'b1;
        tick(1);
        init_ack = 1'b0;
        check("R7 reinit cleared by ack", init_required, 0);
        tick(2);
    endtask

    task automatic t_ignored();
        pulse_exit();
        tick(2);
        pulse_pd();
        tick(1);
        check("R11 entry after stray exit", cke, 0);
        tick(TCKE + 3);
        check("R11 exit request in idle discarded", cke, 0);
        pulse_dpd();
        pulse_exit();
        tick(TXP + 6);
        check("R11 mode idle after exit", mode, 0);
        check("R11 deep request in power-down discarded", cke, 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_pd_precharge();
        t_pd_active_limit();
        t_pd_busy_hold();
        t_dpd_cycle();
        t_ignored();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule